// File: doc/BRIEF.md
# Linear Pitch to Oscillator Frequency Pipeline

This block turns a linear pitch word into the frequency words that oscillators and filters use. The linear word is unsigned, 32 bits, and uses a 5.27 octave format: the top five bits count whole octaves and the lower 27 bits hold the fraction of an octave. The top of the linear scale is defined as the note C9, about 8.372 kHz. A signed global pitch offset is added first, and the sum saturates at both ends. The result then passes through a base-2 exponential unit. This unit reads 2^fraction from a small table, interpolates linearly between table entries, and shifts the result left by the octave count.

Two fixed fractions scale the exponential word. An oscillator constant produces the tuning word for a 32-bit phase accumulator. The accumulator advances once for each audio sample strobe, at about 48.014 kHz, so the output pitch matches A440 tuning. A second constant, four times the first, produces the filter frequency word and makes up for the filter's built-in divide by four. The block exposes the exponential bus, the filter word and the accumulator phase.

Top module: `lpn_top`

## Requirements
- R1: The offset stage adds the signed two's-complement offset to the unsigned linear pitch. If the sum is negative, it is clamped to 0. A clamped sum gives an exponential output of exactly 1.
- R2: If the offset sum is greater than 0xFFFFFFFF, it is clamped to 0xFFFFFFFF. The exponential output is then identical to the output for a linear input of 0xFFFFFFFF with zero offset.
- R3: For a linear value L, the exponential bus equals 2^(L/2^27). The error is at most 4e-6 relative plus 2 LSB. Adding 1<<27 to L (one octave) gives a new output E2 that satisfies 2*E1 <= E2 <= 2*E1+1.
- R4: A linear input of 0xFFFFFFFF gives an exponential output of at least 0xFFFF0000, which is essentially full scale.
- R5: A change on pitch or offset, sampled at one rising edge, appears on the exponential bus at the fourth rising edge counted from that edge. One cycle is spent on the offset stage and three on the exponential.
- R6: The filter word is the upper 32 bits of exp_bus × 0xB28CBE13. It is registered one cycle after the exponential bus.
- R7: On each clock where sample_en is high, the phase advances by the tuning word. The tuning word is the upper 32 bits of exp_bus × 0x2CA32F85. The phase wraps modulo 2^32.
- R8: While sample_en is low, the phase holds its value.
- R9: A synchronous active-high reset clears the phase, the exponential bus and the filter word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pitch_lin | input | 32 | Linear pitch, 5.27 octave format |
| pitch_offset | input | 32 | Signed global pitch offset on the linear scale |
| sample_en | input | 1 | One-cycle strobe per audio sample |
| exp_bus | output | 32 | Exponential frequency word |
| filt_word | output | 32 | Filter frequency word |
| phase | output | 32 | Phase accumulator value |

## Verification
Some behaviours are checked on every cycle by assertions:
- the clamp at both ends of the offset stage;
- the filter word against the exponential bus of the cycle before;
- each phase step against the internal tuning word;
- phase hold while no strobe is present.

Other behaviours only the bench scenarios can show. These are the accuracy of the table and interpolation against a true power of two, the exact doubling per octave, the near-full-scale output at the top of the range, the four-cycle latency, and phase wrap over several strobes.

// File: rtl/lpn_pkg.sv
package lpn_pkg;
   // Oscillator scale: C9 over the sample rate, as an unsigned 0.32 fraction
   localparam logic [31:0] K_OSC_DEF  = 32'h2CA32F85;
   // Filter scale: four times the oscillator scale
   localparam logic [31:0] K_FILT_DEF = 32'hB28CBE13;
   localparam int unsigned PITCH_W_DEF = 32;
   localparam int unsigned OCT_W_DEF   = 5;
endpackage

// File: rtl/lpn_offset_sat.sv
module lpn_offset_sat #(
   parameter int unsigned PITCH_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PITCH_W-1:0] pitch_i,
   input  logic [PITCH_W-1:0] offset_i,
   output logic [PITCH_W-1:0] lin_o
);
   localparam int unsigned SUM_W = PITCH_W + 2;

   logic signed [SUM_W-1:0] sum;

   always_comb begin
      sum = $signed({2'b00, pitch_i}) + $signed({{2{offset_i[PITCH_W-1]}}, offset_i});
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lin_o <= '0;
      end else if (sum[SUM_W-1]) begin
         lin_o <= '0;
      end else if (sum[PITCH_W]) begin
         lin_o <= '1;
      end else begin
         lin_o <= sum[PITCH_W-1:0];
      end
   end
endmodule

// File: rtl/lpn_exp2.sv
module lpn_exp2 #(
   parameter int unsigned PITCH_W    = 32,
   parameter int unsigned OCT_W      = 5,
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned INTERP_W   = 16,
   parameter bit          USE_INTERP = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PITCH_W-1:0] lin_i,
   output logic [PITCH_W-1:0] exp_o
);
   localparam int unsigned FRAC_W  = PITCH_W - OCT_W;
   localparam int unsigned TABLE_N = 1 << IDX_W;
   localparam int unsigned MANT_W  = PITCH_W + 1;
   localparam int unsigned LOW_W   = FRAC_W - IDX_W - INTERP_W;

   if (PITCH_W != (1 << OCT_W)) begin : g_bad_oct
      $error("lpn_exp2: PITCH_W must equal 2**OCT_W");
   end
   if (IDX_W + INTERP_W > FRAC_W) begin : g_bad_frac
      $error("lpn_exp2: table index and interpolation bits exceed fraction");
   end
   if (PITCH_W > 60) begin : g_bad_width
      $error("lpn_exp2: PITCH_W too wide for table construction");
   end

   typedef logic [MANT_W-1:0] lut_t [0:TABLE_N];

   function automatic lut_t build_lut();
      lut_t t;
      real  v;
      for (int i = 0; i <= TABLE_N; i++) begin
         v    = 2.0 ** (real'(i) / real'(TABLE_N));
         t[i] = MANT_W'(longint'(v * (2.0 ** (PITCH_W - 1))));
      end
      return t;
   endfunction

   localparam lut_t LUT = build_lut();

   logic [IDX_W-1:0]  idx;
   logic [OCT_W-1:0]  oct1_q, oct2_q;
   logic [MANT_W-1:0] base_q;
   logic [MANT_W-1:0] mant_q;

   assign idx = lin_i[FRAC_W-1 -: IDX_W];

   if (LOW_W > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^lin_i[LOW_W-1:0];
   end

   // stage 1: table lookup
   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         oct1_q <= '0;
      end else begin
         base_q <= LUT[idx];
         oct1_q <= lin_i[PITCH_W-1 -: OCT_W];
      end
   end

   // stage 2: mantissa, with or without interpolation
   if (USE_INTERP) begin : g_interp
      logic [MANT_W-1:0]          delta_q;
      logic [INTERP_W-1:0]        w_q;
      logic [MANT_W+INTERP_W-1:0] prod;
      logic [IDX_W:0]             idx_nx;

      assign idx_nx = {1'b0, idx} + 1'b1;
      assign prod   = {{INTERP_W{1'b0}}, delta_q} * {{MANT_W{1'b0}}, w_q};

      always_ff @(posedge clk) begin
         if (rst) begin
            delta_q <= '0;
            w_q     <= '0;
         end else begin
            delta_q <= LUT[idx_nx] - LUT[idx];
            w_q     <= lin_i[FRAC_W-IDX_W-1 -: INTERP_W];
         end
      end

      always_ff @(posedge clk) begin
         if (rst) mant_q <= '0;
         else     mant_q <= base_q + prod[MANT_W+INTERP_W-1:INTERP_W];
      end
   end else begin : g_plain
      logic unused_w;
      assign unused_w = ^lin_i[FRAC_W-IDX_W-1 -: INTERP_W];
      always_ff @(posedge clk) begin
         if (rst) mant_q <= '0;
         else     mant_q <= base_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) oct2_q <= '0;
      else     oct2_q <= oct1_q;
   end

   // stage 3: octave shift (shift right by PITCH_W-1-oct, i.e. ~oct)
   logic [MANT_W-1:0] shifted;
   assign shifted = mant_q >> (~oct2_q);

   always_ff @(posedge clk) begin
      if (rst) exp_o <= '0;
      else     exp_o <= shifted[PITCH_W-1:0];
   end

   logic unused_top;
   assign unused_top = shifted[MANT_W-1];
endmodule

// File: rtl/lpn_scale.sv
module lpn_scale #(
   parameter int unsigned PITCH_W = 32,
   parameter logic [PITCH_W-1:0] K = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PITCH_W-1:0] val_i,
   output logic [PITCH_W-1:0] val_o
);
   localparam int unsigned PROD_W = 2 * PITCH_W;

   logic [PROD_W-1:0] prod;
   assign prod = {{PITCH_W{1'b0}}, val_i} * {{PITCH_W{1'b0}}, K};

   always_ff @(posedge clk) begin
      if (rst) val_o <= '0;
      else     val_o <= prod[PROD_W-1:PITCH_W];
   end

   logic unused_lo;
   assign unused_lo = ^prod[PITCH_W-1:0];
endmodule

// File: rtl/lpn_phase_acc.sv
module lpn_phase_acc #(
   parameter int unsigned PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_en,
   input  logic [PHASE_W-1:0] step_i,
   output logic [PHASE_W-1:0] phase_o
);
   always_ff @(posedge clk) begin
      if (rst)          phase_o <= '0;
      else if (step_en) phase_o <= phase_o + step_i;
   end
endmodule

// File: rtl/lpn_top.sv
module lpn_top
   import lpn_pkg::*;
#(
   parameter int unsigned PITCH_W    = PITCH_W_DEF,
   parameter int unsigned OCT_W      = OCT_W_DEF,
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned INTERP_W   = 16,
   parameter bit          USE_INTERP = 1'b1,
   parameter logic [PITCH_W-1:0] K_OSC  = K_OSC_DEF,
   parameter logic [PITCH_W-1:0] K_FILT = K_FILT_DEF
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PITCH_W-1:0] pitch_lin,
   input  logic [PITCH_W-1:0] pitch_offset,
   input  logic               sample_en,
   output logic [PITCH_W-1:0] exp_bus,
   output logic [PITCH_W-1:0] filt_word,
   output logic [PITCH_W-1:0] phase
);
   logic [PITCH_W-1:0] lin_sat;
   logic [PITCH_W-1:0] tune_word;

   lpn_offset_sat #(.PITCH_W(PITCH_W)) u_off (
      .clk(clk), .rst(rst), .pitch_i(pitch_lin), .offset_i(pitch_offset), .lin_o(lin_sat)
   );

   lpn_exp2 #(
      .PITCH_W(PITCH_W), .OCT_W(OCT_W), .IDX_W(IDX_W),
      .INTERP_W(INTERP_W), .USE_INTERP(USE_INTERP)
   ) u_exp (
      .clk(clk), .rst(rst), .lin_i(lin_sat), .exp_o(exp_bus)
   );

   lpn_scale #(.PITCH_W(PITCH_W), .K(K_OSC)) u_osc_k (
      .clk(clk), .rst(rst), .val_i(exp_bus), .val_o(tune_word)
   );

   lpn_scale #(.PITCH_W(PITCH_W), .K(K_FILT)) u_filt_k (
      .clk(clk), .rst(rst), .val_i(exp_bus), .val_o(filt_word)
   );

   lpn_phase_acc #(.PHASE_W(PITCH_W)) u_acc (
      .clk(clk), .rst(rst), .step_en(sample_en), .step_i(tune_word), .phase_o(phase)
   );
endmodule

// File: rtl/lpn_checker.sv
module lpn_checker #(
   parameter int unsigned PITCH_W = 32,
   parameter logic [PITCH_W-1:0] K_FILT = '0
) (
   input logic               clk,
   input logic               rst,
   input logic [PITCH_W-1:0] pitch_lin,
   input logic [PITCH_W-1:0] pitch_offset,
   input logic               sample_en,
   input logic [PITCH_W-1:0] lin_sat,
   input logic [PITCH_W-1:0] exp_bus,
   input logic [PITCH_W-1:0] tune_word,
   input logic [PITCH_W-1:0] filt_word,
   input logic [PITCH_W-1:0] phase
);
   logic signed [PITCH_W+1:0] raw_sum;
   assign raw_sum = $signed({2'b00, pitch_lin}) + $signed({{2{pitch_offset[PITCH_W-1]}}, pitch_offset});

   AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
      (raw_sum < 0) |=> (lin_sat == '0)); // R1

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
      (raw_sum > $signed({2'b00, {PITCH_W{1'b1}}})) |=> (lin_sat == '1)); // R2

   AST_FILT_SCALE: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (filt_word == PITCH_W'(({{PITCH_W{1'b0}}, $past(exp_bus)} * {{PITCH_W{1'b0}}, K_FILT}) >> PITCH_W))); // R6

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      sample_en |=> (phase == $past(phase) + $past(tune_word))); // R7

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !sample_en |=> $stable(phase)); // R8
endmodule

bind lpn_top lpn_checker #(.PITCH_W(PITCH_W), .K_FILT(K_FILT)) u_chk (
   .clk(clk), .rst(rst), .pitch_lin(pitch_lin), .pitch_offset(pitch_offset),
   .sample_en(sample_en), .lin_sat(lin_sat), .exp_bus(exp_bus),
   .tune_word(tune_word), .filt_word(filt_word), .phase(phase)
);

// File: tb/tb_lpn_top.sv
module tb_lpn_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pitch_lin = '0;
   logic [31:0] pitch_offset = '0;
   logic        sample_en = 1'b0;
   logic [31:0] exp_bus, filt_word, phase;

   int n_tests = 0;
   int n_fail  = 0;

   localparam logic [63:0] KO = 64'h2CA32F85;
   localparam logic [63:0] KF = 64'hB28CBE13;

   always #2 clk = ~clk;

   lpn_top dut (
      .clk(clk), .rst(rst), .pitch_lin(pitch_lin), .pitch_offset(pitch_offset),
      .sample_en(sample_en), .exp_bus(exp_bus), .filt_word(filt_word), .phase(phase)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_true(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] upper(input logic [31:0] v, input logic [63:0] k);
      logic [63:0] p;
      p = {32'b0, v} * k;
      return p[63:32];
   endfunction

   task automatic apply(input logic [31:0] p, input logic [31:0] o);
      @(negedge clk);
      pitch_lin = p;
      pitch_offset = o;
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse_sample();
      @(negedge clk);
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 exp_bus in reset", exp_bus, 32'h0);
      check("R9 filt_word in reset", filt_word, 32'h0);
      check("R9 phase in reset", phase, 32'h0);
   endtask

   task automatic t_accuracy(input logic [31:0] lin);
      real e, d;
      apply(lin, 32'h0);
      e = 2.0 ** (real'(lin) / (2.0 ** 27));
      d = real'(exp_bus) - e;
      if (d < 0.0) d = -d;
      check_true("R3 exp accuracy", d <= e * 4.0e-6 + 2.0, exp_bus, 32'(longint'(e)));
   endtask

   task automatic t_octave(input logic [31:0] lin);
      logic [31:0] e1, e2;
      apply(lin, 32'h0);
      e1 = exp_bus;
      apply(lin + 32'h0800_0000, 32'h0);
      e2 = exp_bus;
      check_true("R3 octave doubling", (e2 >= {e1[30:0], 1'b0}) && (e2 <= {e1[30:0], 1'b1}),
                 e2, {e1[30:0], 1'b0});
   endtask

   task automatic t_fullscale();
      apply(32'hFFFF_FFFF, 32'h0);
      check_true("R4 full scale", exp_bus >= 32'hFFFF_0000, exp_bus, 32'hFFFF_0000);
   endtask

   task automatic t_sat_low();
      apply(32'h0000_0010, 32'hFFFF_FF00);
      check("R1 negative sum clamps to 0", exp_bus, 32'h1);
      apply(32'h0000_0000, 32'h8000_0000);
      check("R1 most negative offset", exp_bus, 32'h1);
   endtask

   task automatic t_offset_add();
      logic [31:0] ref_v;
      apply(32'h4800_0000, 32'h0);
      ref_v = exp_bus;
      apply(32'h4000_0000, 32'h0800_0000);
      check("R1 positive offset adds", exp_bus, ref_v);
      apply(32'h5000_0000, 32'hF800_0000);
      check("R1 negative offset subtracts", exp_bus, ref_v);
   endtask

   task automatic t_sat_high();
      logic [31:0] ref_v;
      apply(32'hFFFF_FFFF, 32'h0);
      ref_v = exp_bus;
      apply(32'hF000_0000, 32'h7FFF_FFFF);
      check("R2 overflow clamps to max", exp_bus, ref_v);
   endtask

   task automatic t_latency();
      logic [31:0] a_val, b_val;
      apply(32'h3000_0000, 32'h0);
      a_val = exp_bus;
      apply(32'h6400_0000, 32'h0);
      b_val = exp_bus;
      apply(32'h3000_0000, 32'h0);
      @(negedge clk);
      pitch_lin = 32'h6400_0000;
      repeat (3) @(negedge clk);
      check("R5 unchanged after 3 edges", exp_bus, a_val);
      @(negedge clk);
      check("R5 updated at 4th edge", exp_bus, b_val);
   endtask

   task automatic t_filter(input logic [31:0] lin);
      apply(lin, 32'h0);
      check("R6 filter word", filt_word, upper(exp_bus, KF));
   endtask

   task automatic t_phase(input logic [31:0] lin, input int n);
      logic [31:0] tw, exp_ph;
      apply(lin, 32'h0);
      do_reset();
      repeat (4) @(negedge clk);
      check("R9 phase cleared by reset", phase, 32'h0);
      tw = upper(exp_bus, KO);
      for (int i = 0; i < n; i++) begin
         pulse_sample();
         repeat (i % 3) @(negedge clk);
      end
      exp_ph = 32'(longint'(n) * longint'(tw));
      check("R7 phase after strobes", phase, exp_ph);
      repeat (10) @(negedge clk);
      check("R8 phase holds without strobe", phase, exp_ph);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_accuracy(32'h0000_0000);
      t_accuracy(32'h4800_0000);
      t_accuracy(32'h8A5C_3F17);
      t_accuracy(32'hC123_4567);
      t_accuracy(32'hF7FF_FFFF);
      t_octave(32'h2B3C_9D01);
      t_octave(32'hE9A0_0F0F);
      t_fullscale();
      t_sat_low();
      t_offset_add();
      t_sat_high();
      t_latency();
      t_filter(32'hFFFF_FFFF);
      t_filter(32'hD00D_1234);
      t_phase(32'hE400_0000, 5);
      t_phase(32'hFFFF_FFFF, 9);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule